// File: doc/BRIEF.md
# Snooping Three-State Coherence Controller

This block sits beside one small direct-mapped cache in a shared-bus multiprocessor and keeps the cache coherent with its peers. For every line it keeps a tag, a data word and a coherence state. The state is invalid, shared (clean and read-only) or exclusive (the only copy, writable and possibly newer than memory). The low `IDX_W` bits of an address select the line, and the remaining upper bits form the tag.

On the processor side it serves reads and writes. Hits are served locally. Misses, upgrades and evictions of owned lines become transactions on the shared bus. On the bus side it watches transactions from other caches. It drops its copy when another cache wants to write, and it hands over its data when it owns a block that someone else asks for. Only one request is outstanding at a time. While that request is out, the processor port shows not-ready and no response.

Top module: `msi_snoop_ctrl`

## Requirements
- R1: After reset every line is invalid, `cpuReady` is 1 and `busReq`, `cpuAck` and `snpSupply` are 0.
- R2: A read whose tag matches a shared or exclusive line pulses `cpuAck` one cycle after acceptance, with the stored word on `cpuRdata`. No bus request is made.
- R3: A read that misses requests the bus with `busCmd`=1 (read miss) and the request address. After grant and `busDataValid` it acknowledges with `busRdata`, and the line becomes shared.
- R4: A write that misses requests the bus with `busCmd`=2 (write miss). When the data arrives the line becomes exclusive and holds the written word.
- R5: A write to a shared line that hits issues `busCmd`=2 before completing, and then leaves the line exclusive.
- R6: A write to an exclusive line that hits completes locally and acknowledges the next cycle, with no bus request.
- R7: A read or write whose line is exclusive under a different tag first issues `busCmd`=3 (write back), carrying the old address and data. Only after that does it issue its miss. The write back is issued once.
- R8: A read or write whose line is shared under a different tag issues its miss directly, with no write back.
- R9: A snooped read miss (`snpCmd`=1) to a line held exclusive raises `snpSupply` in the next cycle, with the line's data on `snpData`. The line becomes shared.
- R10: A snooped write miss (`snpCmd`=2) to a shared line invalidates it without supplying data. A later access with the same tag to the invalid line is a miss.
- R11: A snooped write miss to an exclusive line supplies its data in the next cycle and then invalidates the line.
- R12: A snooped read miss to a shared line, a snooped write back (`snpCmd`=3), or any snoop whose tag differs causes no supply and leaves the line unchanged.
- R13: From acceptance of a request that needs the bus until its acknowledge, `cpuReady` and `cpuAck` stay 0. A pending bus request holds its command and address until granted.
- R14: In a cycle with `snpValid` high, `cpuReady` is 0 and no processor request is taken. A request to the same line is then served against the state the snoop left.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| cpuReq | input | 1 | Processor request; taken on a rising edge where `cpuReady` is 1 |
| cpuWe | input | 1 | 1 = write, 0 = read |
| cpuAddr | input | ADDR_W | Request address |
| cpuWdata | input | DATA_W | Write data |
| cpuReady | output | 1 | Controller can take a request this cycle |
| cpuAck | output | 1 | One-cycle completion pulse |
| cpuRdata | output | DATA_W | Read data, valid with `cpuAck` |
| busReq | output | 1 | Bus request |
| busCmd | output | 2 | 0 none, 1 read miss, 2 write miss, 3 write back |
| busAddr | output | ADDR_W | Transaction address |
| busWdata | output | DATA_W | Write-back data |
| busGnt | input | 1 | Grant; the transaction is issued in this cycle |
| busDataValid | input | 1 | Fill data present on `busRdata` |
| busRdata | input | DATA_W | Fill data |
| snpValid | input | 1 | A transaction from another cache is on the bus |
| snpCmd | input | 2 | Snooped command, same coding as `busCmd` |
| snpAddr | input | ADDR_W | Snooped address |
| snpSupply | output | 1 | This cache supplies or writes back the snooped block |
| snpData | output | DATA_W | Supplied block data |

## Verification
The bench targets a tag that matches a line which is no longer valid. A design that trusted the tag alone would return stale data with no bus traffic. It evicts an owned line on a conflict, where a missing or doubled write back would lose the written word or store it twice in memory. It upgrades a shared line on a write, where a controller that completed locally would leave another cache's copy live. It sends snoops at owned and shared lines, where a wrong supply or a missed demotion would show as wrong `snpSupply`, wrong memory contents or a silent later write. A snoop and a read arriving together check that the read sees the state the snoop left, and not a hit on a line that was just invalidated.

// File: rtl/msi_pkg.sv
package msi_pkg;

  typedef enum logic [1:0] {
    LS_INV = 2'd0,
    LS_SHR = 2'd1,
    LS_EXC = 2'd2
  } lineState_t;

  typedef enum logic [1:0] {
    BC_NONE   = 2'd0,
    BC_RDMISS = 2'd1,
    BC_WRMISS = 2'd2,
    BC_WBACK  = 2'd3
  } busCmd_t;

  // strobes from the control FSM to the line store
  typedef struct packed {
    logic       latchReq;
    logic       readOut;
    logic       hitWrite;
    logic       victimDrop;
    logic       fill;
    logic       snpApply;
    logic       snpCapture;
    lineState_t snpNext;
  } lineStrobe_t;

endpackage

// File: rtl/msi_line_store.sv
module msi_line_store
  import msi_pkg::*;
#(
  parameter int ADDR_W = 8,
  parameter int DATA_W = 16,
  parameter int IDX_W  = 2
) (
  input  logic              clk,
  input  logic              rstN,
  input  lineStrobe_t       strb,
  input  logic [ADDR_W-1:0] cpuAddr,
  input  logic              cpuWe,
  input  logic [DATA_W-1:0] cpuWdata,
  input  logic [ADDR_W-1:0] snpAddr,
  input  logic [DATA_W-1:0] busRdata,
  output lineState_t        liveState,
  output logic              liveTagEq,
  output lineState_t        heldState,
  output logic              heldTagEq,
  output logic              heldWe,
  output logic [ADDR_W-1:0] heldAddr,
  output logic [ADDR_W-1:0] victimAddr,
  output logic [DATA_W-1:0] victimData,
  output lineState_t        snpState,
  output logic              snpTagEq,
  output logic [DATA_W-1:0] rdataQ,
  output logic [DATA_W-1:0] snpDataQ
);
  localparam int TAG_W     = ADDR_W - IDX_W;
  localparam int NUM_LINES = 1 << IDX_W;

  lineState_t        stArr   [NUM_LINES];
  logic [TAG_W-1:0]  tagArr  [NUM_LINES];
  logic [DATA_W-1:0] dataArr [NUM_LINES];

  logic [ADDR_W-1:0] reqAddr;
  logic              reqWe;
  logic [DATA_W-1:0] reqData;

  logic [IDX_W-1:0]  liveIdx, heldIdx, snpIdx;
  logic [TAG_W-1:0]  liveTag, heldTag, snpTag;
  logic [DATA_W-1:0] fillData;

  assign liveIdx = cpuAddr[IDX_W-1:0];
  assign liveTag = cpuAddr[ADDR_W-1:IDX_W];
  assign heldIdx = reqAddr[IDX_W-1:0];
  assign heldTag = reqAddr[ADDR_W-1:IDX_W];
  assign snpIdx  = snpAddr[IDX_W-1:0];
  assign snpTag  = snpAddr[ADDR_W-1:IDX_W];

  assign liveState  = stArr[liveIdx];
  assign liveTagEq  = (tagArr[liveIdx] == liveTag);
  assign heldState  = stArr[heldIdx];
  assign heldTagEq  = (tagArr[heldIdx] == heldTag);
  assign heldWe     = reqWe;
  assign heldAddr   = reqAddr;
  assign victimAddr = {tagArr[heldIdx], heldIdx};
  assign victimData = dataArr[heldIdx];
  assign snpState   = stArr[snpIdx];
  assign snpTagEq   = (tagArr[snpIdx] == snpTag);
  assign fillData   = reqWe ? reqData : busRdata;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      for (int i = 0; i < NUM_LINES; i++) begin
        stArr[i]   <= LS_INV;
        tagArr[i]  <= '0;
        dataArr[i] <= '0;
      end
      reqAddr  <= '0;
      reqWe    <= 1'b0;
      reqData  <= '0;
      rdataQ   <= '0;
      snpDataQ <= '0;
    end else begin
      if (strb.latchReq) begin
        reqAddr <= cpuAddr;
        reqWe   <= cpuWe;
        reqData <= cpuWdata;
      end
      if (strb.readOut) rdataQ <= dataArr[liveIdx];
      if (strb.hitWrite) begin
        dataArr[liveIdx] <= cpuWdata;
        rdataQ           <= cpuWdata;
      end
      if (strb.victimDrop) stArr[heldIdx] <= LS_INV;
      if (strb.fill) begin
        tagArr[heldIdx]  <= heldTag;
        dataArr[heldIdx] <= fillData;
        stArr[heldIdx]   <= reqWe ? LS_EXC : LS_SHR;
        rdataQ           <= fillData;
      end
      if (strb.snpCapture) snpDataQ <= dataArr[snpIdx];
      // snoop update placed last: it takes the line if both touch it
      if (strb.snpApply) stArr[snpIdx] <= strb.snpNext;
    end
  end

endmodule

// File: rtl/msi_ctrl.sv
module msi_ctrl
  import msi_pkg::*;
(
  input  logic        clk,
  input  logic        rstN,
  input  logic        cpuReq,
  input  logic        cpuWe,
  input  logic        busGnt,
  input  logic        busDataValid,
  input  logic        snpValid,
  input  logic [1:0]  snpCmd,
  input  lineState_t  liveState,
  input  logic        liveTagEq,
  input  lineState_t  heldState,
  input  logic        heldTagEq,
  input  logic        heldWe,
  input  lineState_t  snpState,
  input  logic        snpTagEq,
  output lineStrobe_t strb,
  output logic        cpuReady,
  output logic        cpuAckQ,
  output logic        busReq,
  output busCmd_t     busCmdO,
  output logic        selVictim,
  output logic        snpSupplyQ
);
  typedef enum logic [1:0] {ST_IDLE, ST_WBACK, ST_MISS, ST_WAIT} ctrlSt_t;

  ctrlSt_t curSt, nextSt;
  logic    ackNext, supplyNext;
  logic    snpHit, liveHit, victimDirty, heldDirty, cpuAccept;

  assign snpHit      = snpValid && (snpState != LS_INV) && snpTagEq;
  assign liveHit     = (liveState != LS_INV) && liveTagEq;
  assign victimDirty = (liveState == LS_EXC) && !liveTagEq;
  assign heldDirty   = (heldState == LS_EXC) && !heldTagEq;
  assign cpuReady    = (curSt == ST_IDLE) && !snpValid;
  assign cpuAccept   = cpuReady && cpuReq;

  always_comb begin
    strb       = '0;
    nextSt     = curSt;
    ackNext    = 1'b0;
    supplyNext = 1'b0;
    busReq     = 1'b0;
    busCmdO    = BC_NONE;
    selVictim  = 1'b0;

    // bus side
    if (snpHit) begin
      if (snpCmd == BC_RDMISS && snpState == LS_EXC) begin
        strb.snpApply   = 1'b1;
        strb.snpNext    = LS_SHR;
        strb.snpCapture = 1'b1;
        supplyNext      = 1'b1;
      end else if (snpCmd == BC_WRMISS) begin
        strb.snpApply = 1'b1;
        strb.snpNext  = LS_INV;
        if (snpState == LS_EXC) begin
          strb.snpCapture = 1'b1;
          supplyNext      = 1'b1;
        end
      end
    end

    // processor side
    unique case (curSt)
      ST_IDLE: begin
        if (cpuAccept) begin
          if (liveHit && (!cpuWe || liveState == LS_EXC)) begin
            ackNext = 1'b1;
            if (cpuWe) strb.hitWrite = 1'b1;
            else       strb.readOut  = 1'b1;
          end else begin
            strb.latchReq = 1'b1;
            nextSt = victimDirty ? ST_WBACK : ST_MISS;
          end
        end
      end
      ST_WBACK: begin
        if (heldDirty) begin
          busReq    = 1'b1;
          busCmdO   = BC_WBACK;
          selVictim = 1'b1;
          if (busGnt) begin
            strb.victimDrop = 1'b1;
            nextSt          = ST_MISS;
          end
        end else begin
          nextSt = ST_MISS;   // a snoop already took the victim
        end
      end
      ST_MISS: begin
        busReq  = 1'b1;
        busCmdO = heldWe ? BC_WRMISS : BC_RDMISS;
        if (busGnt) nextSt = ST_WAIT;
      end
      ST_WAIT: begin
        if (busDataValid) begin
          strb.fill = 1'b1;
          ackNext   = 1'b1;
          nextSt    = ST_IDLE;
        end
      end
      default: nextSt = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      curSt      <= ST_IDLE;
      cpuAckQ    <= 1'b0;
      snpSupplyQ <= 1'b0;
    end else begin
      curSt      <= nextSt;
      cpuAckQ    <= ackNext;
      snpSupplyQ <= supplyNext;
    end
  end

endmodule

// File: rtl/msi_snoop_ctrl.sv
module msi_snoop_ctrl
  import msi_pkg::*;
#(
  parameter int ADDR_W = 8,
  parameter int DATA_W = 16,
  parameter int IDX_W  = 2
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              cpuReq,
  input  logic              cpuWe,
  input  logic [ADDR_W-1:0] cpuAddr,
  input  logic [DATA_W-1:0] cpuWdata,
  output logic              cpuReady,
  output logic              cpuAck,
  output logic [DATA_W-1:0] cpuRdata,
  output logic              busReq,
  output logic [1:0]        busCmd,
  output logic [ADDR_W-1:0] busAddr,
  output logic [DATA_W-1:0] busWdata,
  input  logic              busGnt,
  input  logic              busDataValid,
  input  logic [DATA_W-1:0] busRdata,
  input  logic              snpValid,
  input  logic [1:0]        snpCmd,
  input  logic [ADDR_W-1:0] snpAddr,
  output logic              snpSupply,
  output logic [DATA_W-1:0] snpData
);
  lineStrobe_t       strb;
  lineState_t        liveState, heldState, snpState;
  logic              liveTagEq, heldTagEq, heldWe, snpTagEq, selVictim;
  logic [ADDR_W-1:0] heldAddr, victimAddr;
  logic [DATA_W-1:0] victimData;
  busCmd_t           busCmdE;

  msi_line_store #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .IDX_W(IDX_W)) u_store (
    .clk(clk), .rstN(rstN), .strb(strb),
    .cpuAddr(cpuAddr), .cpuWe(cpuWe), .cpuWdata(cpuWdata),
    .snpAddr(snpAddr), .busRdata(busRdata),
    .liveState(liveState), .liveTagEq(liveTagEq),
    .heldState(heldState), .heldTagEq(heldTagEq), .heldWe(heldWe),
    .heldAddr(heldAddr), .victimAddr(victimAddr), .victimData(victimData),
    .snpState(snpState), .snpTagEq(snpTagEq),
    .rdataQ(cpuRdata), .snpDataQ(snpData)
  );

  msi_ctrl u_ctrl (
    .clk(clk), .rstN(rstN), .cpuReq(cpuReq), .cpuWe(cpuWe),
    .busGnt(busGnt), .busDataValid(busDataValid),
    .snpValid(snpValid), .snpCmd(snpCmd),
    .liveState(liveState), .liveTagEq(liveTagEq),
    .heldState(heldState), .heldTagEq(heldTagEq), .heldWe(heldWe),
    .snpState(snpState), .snpTagEq(snpTagEq),
    .strb(strb), .cpuReady(cpuReady), .cpuAckQ(cpuAck),
    .busReq(busReq), .busCmdO(busCmdE), .selVictim(selVictim),
    .snpSupplyQ(snpSupply)
  );

  assign busCmd   = busCmdE;
  assign busAddr  = selVictim ? victimAddr : heldAddr;
  assign busWdata = victimData;

endmodule

// File: rtl/msi_snoop_checker.sv
module msi_snoop_checker #(
  parameter int ADDR_W = 8
) (
  input logic              clk,
  input logic              rstN,
  input logic              cpuReady,
  input logic              cpuAck,
  input logic              busReq,
  input logic [1:0]        busCmd,
  input logic [ADDR_W-1:0] busAddr,
  input logic              busGnt,
  input logic              snpValid,
  input logic              snpSupply
);
  p_stall_r13: assert property (@(posedge clk) disable iff (!rstN)
    busReq |-> (!cpuReady && !cpuAck));

  p_cmd_quiet_r13: assert property (@(posedge clk) disable iff (!rstN)
    !busReq |-> (busCmd == 2'd0));

  p_req_hold_r13: assert property (@(posedge clk) disable iff (!rstN)
    (busReq && !busGnt && !snpValid) |=> (busReq && $stable(busCmd) && $stable(busAddr)));

  p_wb_once_r7: assert property (@(posedge clk) disable iff (!rstN)
    (busGnt && busReq && busCmd == 2'd3) |=> (busCmd != 2'd3));

  p_supply_cause_r9: assert property (@(posedge clk) disable iff (!rstN)
    snpSupply |-> $past(snpValid));

  p_snoop_first_r14: assert property (@(posedge clk) disable iff (!rstN)
    snpValid |-> !cpuReady);
endmodule

bind msi_snoop_ctrl msi_snoop_checker #(.ADDR_W(ADDR_W)) u_chk (
  .clk(clk), .rstN(rstN), .cpuReady(cpuReady), .cpuAck(cpuAck),
  .busReq(busReq), .busCmd(busCmd), .busAddr(busAddr), .busGnt(busGnt),
  .snpValid(snpValid), .snpSupply(snpSupply)
);

// File: tb/sim_msi_snoop_ctrl.sv
`timescale 1ns/100ps
module sim_msi_snoop_ctrl;
  localparam int AW = 8;
  localparam int DW = 16;
  localparam int IW = 2;
  localparam int NL = 1 << IW;
  localparam int TW = AW - IW;

  logic clk = 1'b0;
  always #2.5 clk = ~clk;

  logic rstN, cpuReq, cpuWe, cpuReady, cpuAck, busReq, busGnt, busDataValid;
  logic snpValid, snpSupply;
  logic [AW-1:0] cpuAddr, busAddr, snpAddr;
  logic [DW-1:0] cpuWdata, cpuRdata, busWdata, busRdata, snpData;
  logic [1:0] busCmd, snpCmd;

  msi_snoop_ctrl #(.ADDR_W(AW), .DATA_W(DW), .IDX_W(IW)) u0 (
    .clk(clk), .rstN(rstN), .cpuReq(cpuReq), .cpuWe(cpuWe), .cpuAddr(cpuAddr),
    .cpuWdata(cpuWdata), .cpuReady(cpuReady), .cpuAck(cpuAck), .cpuRdata(cpuRdata),
    .busReq(busReq), .busCmd(busCmd), .busAddr(busAddr), .busWdata(busWdata),
    .busGnt(busGnt), .busDataValid(busDataValid), .busRdata(busRdata),
    .snpValid(snpValid), .snpCmd(snpCmd), .snpAddr(snpAddr),
    .snpSupply(snpSupply), .snpData(snpData)
  );

  int nChecks = 0;
  int nFails  = 0;
  bit done    = 0;

  logic [DW-1:0] mem [256];
  int            mSt   [NL];   // 0 invalid, 1 shared, 2 exclusive
  logic [TW-1:0] mTag  [NL];
  logic [DW-1:0] mData [NL];

  int            logN;
  logic [1:0]    logCmd  [4];
  logic [AW-1:0] logAddr [4];
  logic [DW-1:0] logData [4];

  task automatic chk(input bit ok, input string tag, input string what,
                     input logic [31:0] act, input logic [31:0] exp);
    nChecks++;
    if (!ok) begin
      nFails++;
      $display("FAIL %s %s: actual %0h expected %0h", tag, what, act, exp);
    end
  endtask

  task automatic finishRun();
    if (!done) begin
      done = 1;
      $display("End of test - %0d assertions evaluated, %0d failures", nChecks, nFails);
      $finish;
    end
  endtask

  // bus: grant, memory and fill data
  initial begin
    logic [1:0]    lcmd;
    logic [AW-1:0] laddr;
    logic [DW-1:0] lwd;
    busGnt = 0; busDataValid = 0; busRdata = '0;
    forever begin
      @(negedge clk);
      if (busReq && rstN) begin
        repeat ($urandom_range(2, 0)) @(negedge clk);
        lcmd = busCmd; laddr = busAddr; lwd = busWdata;
        if (logN < 4) begin
          logCmd[logN] = lcmd; logAddr[logN] = laddr; logData[logN] = lwd;
        end
        logN++;
        busGnt = 1;
        @(negedge clk);
        busGnt = 0;
        if (lcmd == 2'd3) mem[laddr] = lwd;
        else begin
          repeat ($urandom_range(2, 0)) @(negedge clk);
          busRdata = mem[laddr];
          busDataValid = 1;
          @(negedge clk);
          busDataValid = 0;
        end
      end
    end
  end

  task automatic cpuOp(input bit we, input logic [AW-1:0] a, input logic [DW-1:0] wd);
    int            idx = int'(a[IW-1:0]);
    logic [TW-1:0] tg  = a[AW-1:IW];
    bit            hit = (mSt[idx] != 0) && (mTag[idx] == tg);
    bit            local_ = hit && (!we || mSt[idx] == 2);
    bit            wb  = (mSt[idx] == 2) && !hit;
    bit            shv = (mSt[idx] == 1) && !hit;
    int            eN  = 0;
    logic [1:0]    eCmd [2];
    logic [AW-1:0] eAddr [2];
    logic [DW-1:0] expRd = hit ? mData[idx] : mem[a];
    logic [DW-1:0] wbData = mData[idx];
    string         tag, btag;
    bit            stallBad = 0;
    int            n = 0;
    if (!we) tag = hit ? "R2" : "R3";
    else     tag = !hit ? "R4" : (mSt[idx] == 2 ? "R6" : "R5");
    btag = wb ? "R7" : (shv ? "R8" : tag);
    if (wb) begin eCmd[0] = 2'd3; eAddr[0] = {mTag[idx], a[IW-1:0]}; eN = 1; end
    if (!local_) begin eCmd[eN] = we ? 2'd2 : 2'd1; eAddr[eN] = a; eN++; end
    logN = 0;
    @(negedge clk);
    cpuReq = 1; cpuWe = we; cpuAddr = a; cpuWdata = wd;
    #1;
    while (!cpuReady) begin @(negedge clk); #1; end
    @(negedge clk);
    cpuReq = 0;
    while (!cpuAck && n < 100) begin
      if (cpuReady) stallBad = 1;
      @(negedge clk); n++;
    end
    chk(cpuAck == 1'b1, tag, "ack", 32'(cpuAck), 32'd1);
    if (!we) chk(cpuRdata == expRd, tag, "read data", 32'(cpuRdata), 32'(expRd));
    chk(logN == eN, btag, "bus transaction count", 32'(logN), 32'(eN));
    for (int i = 0; i < eN && i < logN; i++) begin
      chk(logCmd[i] == eCmd[i], btag, "bus command", 32'(logCmd[i]), 32'(eCmd[i]));
      chk(logAddr[i] == eAddr[i], btag, "bus address", 32'(logAddr[i]), 32'(eAddr[i]));
      if (eCmd[i] == 2'd3)
        chk(logData[i] == wbData, "R7", "write-back data", 32'(logData[i]), 32'(wbData));
    end
    if (!local_) chk(!stallBad, "R13", "ready low while waiting", 32'(stallBad), 32'd0);
    if (local_) begin
      if (we) mData[idx] = wd;
    end else begin
      mSt[idx]   = we ? 2 : 1;
      mTag[idx]  = tg;
      mData[idx] = we ? wd : expRd;
    end
  endtask

  task automatic snoopModel(input logic [1:0] cmd, input logic [AW-1:0] a, output bit expSup,
                            output string tag);
    int            idx = int'(a[IW-1:0]);
    logic [TW-1:0] tg  = a[AW-1:IW];
    bit            match = (mSt[idx] != 0) && (mTag[idx] == tg);
    expSup = match && (mSt[idx] == 2) && (cmd == 2'd1 || cmd == 2'd2);
    if (match && mSt[idx] == 2 && cmd == 2'd1)      tag = "R9";
    else if (match && mSt[idx] == 1 && cmd == 2'd2) tag = "R10";
    else if (match && mSt[idx] == 2 && cmd == 2'd2) tag = "R11";
    else                                             tag = "R12";
  endtask

  task automatic snoopUpdate(input logic [1:0] cmd, input logic [AW-1:0] a);
    int            idx = int'(a[IW-1:0]);
    logic [TW-1:0] tg  = a[AW-1:IW];
    bit            match = (mSt[idx] != 0) && (mTag[idx] == tg);
    if (match && mSt[idx] == 2 && (cmd == 2'd1 || cmd == 2'd2)) mem[a] = mData[idx];
    if (match && cmd == 2'd1 && mSt[idx] == 2) mSt[idx] = 1;
    if (match && cmd == 2'd2) mSt[idx] = 0;
  endtask

  task automatic snoopOp(input logic [1:0] cmd, input logic [AW-1:0] a);
    bit            expSup;
    string         tag;
    logic [DW-1:0] expD = mData[int'(a[IW-1:0])];
    snoopModel(cmd, a, expSup, tag);
    @(negedge clk);
    snpValid = 1; snpCmd = cmd; snpAddr = a;
    @(negedge clk);
    snpValid = 0;
    chk(snpSupply == expSup, tag, "snoop supply", 32'(snpSupply), 32'(expSup));
    if (expSup) chk(snpData == expD, tag, "snoop data", 32'(snpData), 32'(expD));
    snoopUpdate(cmd, a);
  endtask

  // snoop and read in the same cycle
  task automatic sameCycle(input logic [1:0] cmd, input logic [AW-1:0] a);
    bit            expSup;
    string         tag;
    logic [DW-1:0] expD = mData[int'(a[IW-1:0])];
    snoopModel(cmd, a, expSup, tag);
    @(negedge clk);
    snpValid = 1; snpCmd = cmd; snpAddr = a;
    cpuReq = 1; cpuWe = 0; cpuAddr = a;
    #1;
    chk(cpuReady == 1'b0, "R14", "ready during snoop", 32'(cpuReady), 32'd0);
    @(negedge clk);
    snpValid = 0; cpuReq = 0;
    #1;
    chk(cpuReady && !cpuAck, "R14", "request not taken in snoop cycle",
        32'({cpuReady, cpuAck}), 32'b10);
    chk(snpSupply == expSup, tag, "snoop supply", 32'(snpSupply), 32'(expSup));
    if (expSup) chk(snpData == expD, tag, "snoop data", 32'(snpData), 32'(expD));
    snoopUpdate(cmd, a);
    cpuOp(1'b0, a, '0);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    nChecks++; nFails++;
    $display("FAIL watchdog: actual timeout expected completion");
    finishRun();
  end

  initial begin
    void'($urandom(32'h5EED_0042));
    for (int i = 0; i < 256; i++) mem[i] = 16'hA000 ^ 16'(i * 16'h0123);
    for (int i = 0; i < NL; i++) begin mSt[i] = 0; mTag[i] = '0; mData[i] = '0; end
    logN = 0;
    rstN = 0; cpuReq = 0; cpuWe = 0; cpuAddr = '0; cpuWdata = '0;
    snpValid = 0; snpCmd = '0; snpAddr = '0;
    repeat (4) @(negedge clk);
    rstN = 1;
    @(negedge clk);
    chk(cpuReady == 1'b1, "R1", "ready after reset", 32'(cpuReady), 32'd1);
    chk(busReq == 1'b0, "R1", "bus idle after reset", 32'(busReq), 32'd0);
    chk(cpuAck == 1'b0, "R1", "no ack after reset", 32'(cpuAck), 32'd0);
    chk(snpSupply == 1'b0, "R1", "no supply after reset", 32'(snpSupply), 32'd0);

    // directed corner cases
    cpuOp(1'b0, 8'h05, '0);        // R3 read miss
    cpuOp(1'b0, 8'h05, '0);        // R2 read hit shared
    cpuOp(1'b1, 8'h05, 16'h1111);  // R5 upgrade
    cpuOp(1'b1, 8'h05, 16'h2222);  // R6 local write
    cpuOp(1'b0, 8'h05, '0);        // R2 read hit exclusive
    cpuOp(1'b1, 8'h09, 16'h3333);  // R7 evict owned, R4 write miss
    snoopOp(2'd1, 8'h09);          // R9 supply, demote
    cpuOp(1'b0, 8'h09, '0);        // R2 hit after demotion
    snoopOp(2'd1, 8'h09);          // R12 shared, memory serves
    snoopOp(2'd3, 8'h09);          // R12 write back ignored
    snoopOp(2'd2, 8'h19);          // R12 other tag
    snoopOp(2'd2, 8'h09);          // R10 invalidate shared
    cpuOp(1'b0, 8'h09, '0);        // R10 tag match on invalid line misses
    cpuOp(1'b0, 8'h0D, '0);        // R8 shared victim, no write back
    cpuOp(1'b1, 8'h02, 16'h4444);  // R4 write miss
    snoopOp(2'd2, 8'h02);          // R11 supply and invalidate
    cpuOp(1'b0, 8'h02, '0);        // reads the supplied word back from memory
    cpuOp(1'b1, 8'h03, 16'h5555);
    sameCycle(2'd2, 8'h03);        // R14
    cpuOp(1'b0, 8'h07, '0);
    sameCycle(2'd1, 8'h07);        // R14 with no snoop effect

    // constrained random mix
    for (int k = 0; k < 300; k++) begin
      logic [AW-1:0] a;
      a = {4'b0000, 2'($urandom_range(3, 0)), 2'($urandom_range(3, 0))};
      if ($urandom_range(9, 0) < 7) cpuOp(1'($urandom_range(1, 0)), a, 16'($urandom));
      else snoopOp(2'($urandom_range(3, 1)), a);
    end
    repeat (3) @(negedge clk);
    finishRun();
  end

endmodule